// File: doc/BRIEF.md
# BCD Calendar Digit Counter Chain

This block is the timekeeping core of a real-time clock. It keeps seconds, minutes, hours, day of month, month and year as separate BCD units and tens digits, plus a day-of-week counter. Each rising edge of a once-per-second tick advances the seconds. A wrap in one field carries into the next, in the order seconds, minutes, hours, day, month, year. Hours run in either a 24-hour or a 12-hour mode with a PM flag. February gains a 29th day when the year's value modulo 4 equals a remainder chosen by two select bits. This means calendars whose leap years do not fall on multiples of four can be tracked.

A bus front end drives a 4-bit digit address with a write strobe and write data. It reads any digit back through a combinational read port. A freeze input blocks the seconds tick. While the chain is frozen, a rising edge on the test-pulse input injects an increment at the addressed digit, and the carries ripple on from there. This lets later digits be exercised without waiting for real time to pass.

Top module: `rtc_digit_chain`

## Requirements
- R1: With `stop` low, a rising edge on `tick_1hz` advances the seconds by one in the clock cycle where the edge is sampled. Seconds and minutes each count 00 to 59. Wrapping from 59 to 00 carries one into the next field.
- R2: In 24-hour mode (address 5 bit 3 = 1), hours count 00 to 23, and 23 to 00 carries into the day.
- R3: In 12-hour mode (address 5 bit 3 = 0), hours count 1 to 12, and 12 is followed by 1. Passing from 11 to 12 toggles the PM flag (address 5 bit 2). When the toggle clears PM (11 PM to 12 AM), it carries into the day. Writing address 5 with bit 3 = 1 clears PM.
- R4: The day of week (address 6, bits 2:0) counts 0 to 6 and wraps to 0. It advances exactly when the day is stepped by one.
- R5: The day runs from 01 to the month length: 31, 30 for months 4, 6, 9 and 11, and 28 for February. It then restarts at 01 and carries into the month. Months run 01 to 12, and 12 to 01 carries into the year. The year runs 00 to 99 and wraps.
- R6: The select bits are address 8 bit 2 (a) and bit 3 (b). The pair (a,b) sets the leap remainder: 00 gives 0, 10 gives 3, 01 gives 2, and 11 gives 1. February has 29 days when the year value modulo 4 equals that remainder.
- R7: While `stop` is high, `tick_1hz` edges change no digit.
- R8: While `stop` is high, a rising edge on `test_pulse` adds one at a units address (0, 2, 4, 6, 7, 9, 11) or ten at a tens address (1, 3, 5, 8, 10, 12) to that field. A result past the field maximum restarts the field at its minimum and carries on. In 12-hour mode, a result past 12 wraps by subtracting 12. Addresses 6 and 7 both step the day and the day of week. With `stop` low, the test edge is ignored.
- R9: A write to a field in the same cycle as an increment of that field wins. The written digit takes the data, the field does not advance, and it gives no carry.
- R10: The read map is: 0/1 seconds units/tens, 2/3 minutes, 4/5 hours, 6 day of week, 7/8 day, 9/10 month, 11/12 year. Bits with no storage read 0, and addresses 13 to 15 read 0.
- R11: After reset the chain holds 00:00:00 in 24-hour mode with PM clear, day 01, month 01, year 00, day of week 0, and leap select 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | Once-per-second tick; rising edge advances time |
| stop | input | 1 | Freezes the tick and enables test injection |
| test_pulse | input | 1 | Rising edge injects an increment at `addr` |
| addr | input | 4 | Digit address for write, read and test |
| wr_en | input | 1 | Write strobe for the addressed digit |
| wr_data | input | 4 | Write data nibble |
| rd_data | output | 4 | Combinational read of the addressed digit |

## Verification
A parallel load and an increment of the same field can fall in one clock edge. This happens when a write to a digit lands on the cycle where the tick's carry or the tick itself reaches that field. The bench provokes this by raising `tick_1hz` at 59 seconds while writing the minutes units, and again while writing the seconds units. It judges the result by reading back the written digit, the untouched neighbour, and the next field, which must not have received a carry. The freeze-plus-injection path is also crossed with ordinary ticks, to show that each blocks the other.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NIB_W = 4;
  localparam logic [3:0] A_SEC_U = 4'h0;
  localparam logic [3:0] A_SEC_T = 4'h1;
  localparam logic [3:0] A_MIN_U = 4'h2;
  localparam logic [3:0] A_MIN_T = 4'h3;
  localparam logic [3:0] A_HR_U  = 4'h4;
  localparam logic [3:0] A_HR_T  = 4'h5;
  localparam logic [3:0] A_DOW   = 4'h6;
  localparam logic [3:0] A_DAY_U = 4'h7;
  localparam logic [3:0] A_DAY_T = 4'h8;
  localparam logic [3:0] A_MON_U = 4'h9;
  localparam logic [3:0] A_MON_T = 4'hA;
  localparam logic [3:0] A_YR_U  = 4'hB;
  localparam logic [3:0] A_YR_T  = 4'hC;
endpackage

// File: rtl/rtc_edge.sv
module rtc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sig_in;
  end
  assign rise = sig_in & ~prev;
endmodule

// File: rtl/rtc_field.sv
module rtc_field #(
  parameter int TW   = 3,
  parameter int MINV = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          ten,
  input  logic          ld_u,
  input  logic          ld_t,
  input  logic [3:0]    ld_data,
  input  logic [6:0]    max_val,
  output logic [3:0]    q_u,
  output logic [TW-1:0] q_t,
  output logic          carry
);
  logic [7:0] cur, sum, nxt;
  logic       wrap, ld;

  assign ld    = ld_u | ld_t;
  assign cur   = 8'(q_t) * 8'd10 + 8'(q_u);
  assign sum   = cur + (ten ? 8'd10 : 8'd1);
  assign wrap  = sum > {1'b0, max_val};
  assign nxt   = wrap ? 8'(MINV) : sum;
  assign carry = inc & ~ld & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_u <= 4'(MINV % 10);
      q_t <= TW'(MINV / 10);
    end else if (ld) begin
      if (ld_u) q_u <= ld_data;
      if (ld_t) q_t <= ld_data[TW-1:0];
    end else if (inc) begin
      q_u <= 4'(nxt % 8'd10);
      q_t <= TW'(nxt / 8'd10);
    end
  end

  assert_wrap_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (cur == 8'(MINV)));
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_u |=> (q_u == $past(ld_data)));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(cur));
endmodule

// File: rtl/rtc_hours.sv
module rtc_hours (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       ten,
  input  logic       ld_u,
  input  logic       ld_t,
  input  logic [3:0] ld_data,
  output logic [3:0] q_u,
  output logic [1:0] q_t,
  output logic       pm,
  output logic       h24,
  output logic       carry
);
  logic [6:0] cur, sum, nxt;
  logic       tog, wrap_c, ld;

  assign ld  = ld_u | ld_t;
  assign cur = 7'(q_t) * 7'd10 + 7'(q_u);
  assign sum = cur + (ten ? 7'd10 : 7'd1);

  always_comb begin
    tog    = 1'b0;
    wrap_c = 1'b0;
    nxt    = sum;
    if (h24) begin
      if (sum > 7'd23) begin
        nxt    = 7'd0;
        wrap_c = 1'b1;
      end
    end else begin
      if (sum > 7'd12) nxt = sum - 7'd12;
      if (cur < 7'd12 && sum >= 7'd12) begin
        tog    = 1'b1;
        wrap_c = pm;
      end
    end
  end

  assign carry = inc & ~ld & wrap_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_u <= 4'd0;
      q_t <= 2'd0;
      pm  <= 1'b0;
      h24 <= 1'b1;
    end else if (ld) begin
      if (ld_u) q_u <= ld_data;
      if (ld_t) begin
        q_t <= ld_data[1:0];
        h24 <= ld_data[3];
        pm  <= ld_data[3] ? 1'b0 : ld_data[2];
      end
    end else if (inc) begin
      q_u <= 4'(nxt % 7'd10);
      q_t <= 2'(nxt / 7'd10);
      if (tog) pm <= ~pm;
    end
  end

  assert_day_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && h24) |=> (cur == 7'd0));
  assert_noon_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && !h24 && !ten && cur == 7'd11) |=> (pm != $past(pm)) && (cur == 7'd12));
endmodule

// File: rtl/rtc_digit_chain.sv
module rtc_digit_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       stop,
  input  logic       test_pulse,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data
);
  logic tick_rise, test_rise, adv, tst;
  logic [3:0] sec_u, min_u, hr_u, day_u, mon_u, yr_u, yr_t;
  logic [2:0] sec_t, min_t, dow;
  logic [1:0] hr_t, day_t, leap_sel, yr_lo, leap_rem;
  logic [0:0] mon_t;
  logic       pm, h24, is_leap;
  logic       sec_c, min_c, hr_c, day_c, mon_c, yr_c;
  logic       sec_i, min_i, hr_i, day_i, mon_i, yr_i;
  logic [4:0] mon_bin;
  logic [6:0] day_max;
  logic [15:0] we;

  rtc_edge u_tick (.clk(clk), .rst_n(rst_n), .sig_in(tick_1hz),   .rise(tick_rise));
  rtc_edge u_test (.clk(clk), .rst_n(rst_n), .sig_in(test_pulse), .rise(test_rise));

  assign adv = tick_rise & ~stop;
  assign tst = test_rise & stop;

  always_comb begin
    we = '0;
    we[addr] = wr_en;
  end

  // Increment entry points: either the previous carry or a test injection
  assign sec_i = adv   | (tst && (addr == A_SEC_U || addr == A_SEC_T));
  assign min_i = sec_c | (tst && (addr == A_MIN_U || addr == A_MIN_T));
  assign hr_i  = min_c | (tst && (addr == A_HR_U  || addr == A_HR_T));
  assign day_i = hr_c  | (tst && (addr == A_DOW   || addr == A_DAY_U || addr == A_DAY_T));
  assign mon_i = day_c | (tst && (addr == A_MON_U || addr == A_MON_T));
  assign yr_i  = mon_c | (tst && (addr == A_YR_U  || addr == A_YR_T));

  // Month length and leap test
  assign mon_bin  = 5'(mon_t) * 5'd10 + 5'(mon_u);
  assign yr_lo    = yr_u[1:0] + {yr_t[0], 1'b0};
  assign leap_rem = 2'd0 - leap_sel;
  assign is_leap  = (yr_lo == leap_rem);

  always_comb begin
    case (mon_bin)
      5'd2:                         day_max = is_leap ? 7'd29 : 7'd28;
      5'd4, 5'd6, 5'd9, 5'd11:      day_max = 7'd30;
      default:                      day_max = 7'd31;
    endcase
  end

  rtc_field #(.TW(3), .MINV(0)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(sec_i), .ten(tst && addr == A_SEC_T),
    .ld_u(we[A_SEC_U]), .ld_t(we[A_SEC_T]), .ld_data(wr_data), .max_val(7'd59),
    .q_u(sec_u), .q_t(sec_t), .carry(sec_c));

  rtc_field #(.TW(3), .MINV(0)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(min_i), .ten(tst && addr == A_MIN_T),
    .ld_u(we[A_MIN_U]), .ld_t(we[A_MIN_T]), .ld_data(wr_data), .max_val(7'd59),
    .q_u(min_u), .q_t(min_t), .carry(min_c));

  rtc_hours u_hr (
    .clk(clk), .rst_n(rst_n), .inc(hr_i), .ten(tst && addr == A_HR_T),
    .ld_u(we[A_HR_U]), .ld_t(we[A_HR_T]), .ld_data(wr_data),
    .q_u(hr_u), .q_t(hr_t), .pm(pm), .h24(h24), .carry(hr_c));

  rtc_field #(.TW(2), .MINV(1)) u_day (
    .clk(clk), .rst_n(rst_n), .inc(day_i), .ten(tst && addr == A_DAY_T),
    .ld_u(we[A_DAY_U]), .ld_t(we[A_DAY_T]), .ld_data(wr_data), .max_val(day_max),
    .q_u(day_u), .q_t(day_t), .carry(day_c));

  rtc_field #(.TW(1), .MINV(1)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc(mon_i), .ten(tst && addr == A_MON_T),
    .ld_u(we[A_MON_U]), .ld_t(we[A_MON_T]), .ld_data(wr_data), .max_val(7'd12),
    .q_u(mon_u), .q_t(mon_t), .carry(mon_c));

  rtc_field #(.TW(4), .MINV(0)) u_yr (
    .clk(clk), .rst_n(rst_n), .inc(yr_i), .ten(tst && addr == A_YR_T),
    .ld_u(we[A_YR_U]), .ld_t(we[A_YR_T]), .ld_data(wr_data), .max_val(7'd99),
    .q_u(yr_u), .q_t(yr_t), .carry(yr_c));

  // Day of week steps with single-day advances only
  logic dow_step, day_ld;
  assign day_ld   = we[A_DOW] | we[A_DAY_U] | we[A_DAY_T];
  assign dow_step = day_i && !(tst && addr == A_DAY_T) && !day_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow      <= 3'd0;
      leap_sel <= 2'd0;
    end else begin
      if (we[A_DAY_T]) leap_sel <= {wr_data[3], wr_data[2]};
      if (we[A_DOW])   dow <= wr_data[2:0];
      else if (dow_step) dow <= (dow == 3'd6) ? 3'd0 : dow + 3'd1;
    end
  end

  always_comb begin
    case (addr)
      A_SEC_U: rd_data = sec_u;
      A_SEC_T: rd_data = {1'b0, sec_t};
      A_MIN_U: rd_data = min_u;
      A_MIN_T: rd_data = {1'b0, min_t};
      A_HR_U:  rd_data = hr_u;
      A_HR_T:  rd_data = {h24, pm, hr_t};
      A_DOW:   rd_data = {1'b0, dow};
      A_DAY_U: rd_data = day_u;
      A_DAY_T: rd_data = {leap_sel, day_t};
      A_MON_U: rd_data = mon_u;
      A_MON_T: rd_data = {3'b000, mon_t};
      A_YR_U:  rd_data = yr_u;
      A_YR_T:  rd_data = yr_t;
      default: rd_data = 4'h0;
    endcase
  end

  // Year carry leaves the chain: the year simply wraps
  logic unused_ok;
  assign unused_ok = yr_c;

  assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !test_rise && !wr_en) |=> ($stable(sec_u) && $stable(sec_t)));
  assert_dow_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dow_step |=> (dow != $past(dow)));
  assert_test_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !tick_rise && !wr_en) |=> ($stable(sec_u) && $stable(min_u) && $stable(dow)));
endmodule

// File: tb/rtc_digit_chain_bench.sv
module rtc_digit_chain_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0, stop = 1'b0, test_pulse = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'h0, wr_data = 4'h0;
  logic [3:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_digit_chain u_rtc_digit_chain (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .stop(stop),
    .test_pulse(test_pulse), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data));

  task automatic chk(input string tag, input logic [3:0] a, input logic [3:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr=%0h actual=%0h expected=%0h", tag, a, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic tpulse(input logic [3:0] a);
    @(negedge clk); addr = a; test_pulse = 1'b1;
    @(negedge clk); test_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_clock24(input int h, input int m, input int s);
    wr(4'h5, 4'h8 | 4'(h / 10)); wr(4'h4, 4'(h % 10));
    wr(4'h3, 4'(m / 10));        wr(4'h2, 4'(m % 10));
    wr(4'h1, 4'(s / 10));        wr(4'h0, 4'(s % 10));
  endtask

  task automatic set_ms59();
    wr(4'h3, 4'd5); wr(4'h2, 4'd9); wr(4'h1, 4'd5); wr(4'h0, 4'd9);
  endtask

  task automatic set_date(input int y, input int mo, input int d, input logic [1:0] sel);
    wr(4'hC, 4'(y / 10));  wr(4'hB, 4'(y % 10));
    wr(4'hA, 4'(mo / 10)); wr(4'h9, 4'(mo % 10));
    wr(4'h8, {sel, 2'(d / 10)}); wr(4'h7, 4'(d % 10));
  endtask

  task automatic t_reset();
    chk("R11 sec_u", 4'h0, 4'h0); chk("R11 sec_t", 4'h1, 4'h0);
    chk("R11 min_u", 4'h2, 4'h0); chk("R11 hr_t mode", 4'h5, 4'h8);
    chk("R11 dow", 4'h6, 4'h0);   chk("R11 day_u", 4'h7, 4'h1);
    chk("R11 day_t", 4'h8, 4'h0); chk("R11 mon_u", 4'h9, 4'h1);
    chk("R11 yr_t", 4'hC, 4'h0);
  endtask

  task automatic t_seconds();
    set_clock24(10, 20, 30);
    tick();
    chk("R1 sec_u step", 4'h0, 4'h1); chk("R1 sec_t", 4'h1, 4'h3);
    set_clock24(10, 20, 59);
    tick();
    chk("R1 sec wrap", 4'h1, 4'h0); chk("R1 min carry", 4'h2, 4'h1);
    chk("R1 hour unchanged", 4'h4, 4'h0);
  endtask

  task automatic t_day24();
    set_date(7, 3, 15, 2'b00);
    wr(4'h6, 4'h6);
    set_clock24(23, 59, 59);
    tick();
    chk("R2 hr_u", 4'h4, 4'h0); chk("R2 hr_t", 4'h5, 4'h8);
    chk("R2 min_t", 4'h3, 4'h0); chk("R2 day_u", 4'h7, 4'h6);
    chk("R4 dow wrap", 4'h6, 4'h0);
  endtask

  task automatic t_twelve();
    set_date(5, 1, 10, 2'b00);
    wr(4'h5, 4'h5); wr(4'h4, 4'h1); set_ms59();
    tick();
    chk("R3 midnight hr_t", 4'h5, 4'h1); chk("R3 midnight hr_u", 4'h4, 4'h2);
    chk("R3 midnight day", 4'h7, 4'h1);
    wr(4'h5, 4'h1); wr(4'h4, 4'h1); set_ms59();
    tick();
    chk("R3 noon pm", 4'h5, 4'h5); chk("R3 noon day held", 4'h7, 4'h1);
    set_ms59();
    tick();
    chk("R3 twelve to one hr_t", 4'h5, 4'h4); chk("R3 twelve to one hr_u", 4'h4, 4'h1);
    wr(4'h5, 4'hD);
    chk("R3 mode24 clears pm", 4'h5, 4'h9);
  endtask

  task automatic t_month();
    set_date(20, 4, 30, 2'b00);
    set_clock24(23, 59, 59);
    tick();
    chk("R5 apr end mon", 4'h9, 4'h5); chk("R5 apr end day_u", 4'h7, 4'h1);
    chk("R5 apr end day_t", 4'h8, 4'h0);
    set_date(99, 12, 31, 2'b00);
    set_clock24(23, 59, 59);
    tick();
    chk("R5 year wrap yr_t", 4'hC, 4'h0); chk("R5 year wrap yr_u", 4'hB, 4'h0);
    chk("R5 dec to jan mon_t", 4'hA, 4'h0); chk("R5 dec to jan mon_u", 4'h9, 4'h1);
  endtask

  task automatic t_leap();
    set_date(84, 2, 28, 2'b00); set_clock24(23, 59, 59); tick();
    chk("R6 sel00 yr84 day_u", 4'h7, 4'h9); chk("R6 sel00 day_t", 4'h8, 4'h2);
    set_clock24(23, 59, 59); tick();
    chk("R6 feb29 to mar", 4'h9, 4'h3); chk("R6 mar day", 4'h7, 4'h1);
    set_date(83, 2, 28, 2'b01); set_clock24(23, 59, 59); tick();
    chk("R6 rem3 yr83", 4'h7, 4'h9); chk("R6 rem3 sel readback", 4'h8, 4'h6);
    set_date(84, 2, 28, 2'b01); set_clock24(23, 59, 59); tick();
    chk("R6 rem3 yr84 no leap", 4'h9, 4'h3);
    set_date(82, 2, 28, 2'b10); set_clock24(23, 59, 59); tick();
    chk("R6 rem2 yr82", 4'h7, 4'h9);
    set_date(81, 2, 28, 2'b11); set_clock24(23, 59, 59); tick();
    chk("R6 rem1 yr81", 4'h7, 4'h9);
  endtask

  task automatic t_stop();
    stop = 1'b1;
    set_clock24(10, 20, 30);
    tick();
    chk("R7 frozen sec_u", 4'h0, 4'h0); chk("R7 frozen sec_t", 4'h1, 4'h3);
    stop = 1'b0;
    tpulse(4'h0);
    chk("R8 test ignored when running", 4'h0, 4'h0);
  endtask

  task automatic t_inject();
    stop = 1'b1;
    set_clock24(10, 0, 59);
    tpulse(4'h0);
    chk("R8 sec inject wrap", 4'h1, 4'h0); chk("R8 sec inject carry", 4'h2, 4'h1);
    set_clock24(10, 52, 0);
    tpulse(4'h3);
    chk("R8 min tens wrap", 4'h3, 4'h0); chk("R8 min tens carry hr", 4'h4, 4'h1);
    set_date(0, 4, 25, 2'b00);
    wr(4'h6, 4'h3);
    tpulse(4'h6);
    chk("R8 dow addr day_u", 4'h7, 4'h6); chk("R4 dow with day", 4'h6, 4'h4);
    tpulse(4'h8);
    chk("R8 day tens wrap", 4'h7, 4'h1); chk("R8 day tens carry mon", 4'h9, 4'h5);
    chk("R4 dow held on ten step", 4'h6, 4'h4);
    stop = 1'b0;
  endtask

  task automatic t_priority();
    set_clock24(10, 0, 59);
    @(negedge clk); tick_1hz = 1'b1; addr = 4'h2; wr_data = 4'h7; wr_en = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk("R9 sec still wraps", 4'h0, 4'h0); chk("R9 load beats carry", 4'h2, 4'h7);
    chk("R9 hour untouched", 4'h4, 4'h0);
    set_clock24(10, 0, 59);
    @(negedge clk); tick_1hz = 1'b1; addr = 4'h0; wr_data = 4'h3; wr_en = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk("R9 sec_u loaded", 4'h0, 4'h3); chk("R9 sec_t held", 4'h1, 4'h5);
    chk("R9 no carry out", 4'h2, 4'h0);
  endtask

  task automatic t_map();
    wr(4'hA, 4'hF);
    chk("R10 month tens width", 4'hA, 4'h1);
    wr(4'hA, 4'h0);
    chk("R10 addr D reads 0", 4'hD, 4'h0);
    chk("R10 addr E reads 0", 4'hE, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_seconds();
    t_day24();
    t_twelve();
    t_month();
    t_leap();
    t_stop();
    t_inject();
    t_priority();
    t_map();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule